// File: doc/BRIEF.md
# Settings Bus Register Slave

This block is a register bank on the far side of a strobe-based settings bus. Each strobe brings an 8-bit word address and a 32-bit data word, and every strobe is both a write and a read. Addresses below the register count write a 32-bit settings register. One reserved address instead loads the read-back index. Whatever the intent, every strobe is answered by exactly one read-back acknowledge. That acknowledge carries the 64-bit word picked by the current read-back index.

To read, a requester writes the wanted index to the reserved address and takes the data from the acknowledge that follows. To write, it strobes the register address and discards the returned data. Each strobe also carries a 64-bit time value and a timed flag. The block latches both and shows them on status outputs; it does not act on them.

The interface is a pair of plain strobes with no ready signal, so there is no back-pressure. The requester must hold off its next strobe until the acknowledge for the previous one has been seen. A strobe issued while an acknowledge is pending is outside the contract.

Top module: `sbus_reg_slave`

## Requirements
- R1: Synchronous active-high reset clears every settings register, the read-back index, the latched time fields and the acknowledge. A read through the normal interface after reset returns zero.
- R2: Every strobe produces exactly one `ack_stb` pulse, one cycle wide, high in the second cycle after the strobe cycle.
- R3: A strobe to an address below `NUM_REGS` (other than the reserved one) stores `cfg_wdata` into that register on the strobe edge. The acknowledge of that same strobe already sees the new value when the index selects it.
- R4: A strobe to the reserved address `SEL_ADDR` (default 124) loads the read-back index from `cfg_wdata[7:0]`; bits above 7 are ignored. The acknowledge of that same strobe returns the word selected by the new index.
- R5: A read-back index k below `NUM_REGS` (default 64) returns settings register k zero-extended to 64 bits.
- R6: Read-back index `NUM_REGS` (64) returns a 64-bit free-running counter that is cleared by reset and advances by one each clock. Two reads whose strobes are N cycles apart differ by N.
- R7: Read-back indices above `NUM_REGS` return the constant `FILL_WORD` (default 64'hA5A5_5A5A_0123_4567).
- R8: A strobe to an address at or above `NUM_REGS` that is not `SEL_ADDR` changes no register and does not change the index.
- R9: Each strobe latches `cfg_time` and `cfg_timed` onto `last_time` and `last_timed` from the cycle after the strobe.
- R10: Reset asserted while an acknowledge is pending suppresses that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stb | input | 1 | One-cycle settings strobe |
| cfg_addr | input | 8 | Settings word address |
| cfg_wdata | input | 32 | Settings write data |
| cfg_time | input | 64 | Time value carried with the strobe |
| cfg_timed | input | 1 | Flag marking the time value as meaningful |
| ack_stb | output | 1 | One-cycle read-back acknowledge |
| ack_data | output | 64 | Read-back word, valid while `ack_stb` is high |
| last_time | output | 64 | Time value of the most recent strobe |
| last_timed | output | 1 | Timed flag of the most recent strobe |

## Verification
The bench builds the block with its defaults: 64 registers, reserved address 124, and counter index 64. With these values, address 70 aliases register 6 in its low bits, which puts the ignored-write case of R8 within reach. The index values 63, 64, 65 and 255 fall on both sides of the register/counter/constant boundaries. A data word of 0x100 written to the reserved address shows that the index truncates to its low byte.

// File: rtl/sbus_slave_pkg.sv
package sbus_slave_pkg;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_CNT  = 2'd1,
    SRC_FILL = 2'd2
  } rb_src_e;

  // Sort a read-back index into register, counter or constant region.
  function automatic rb_src_e classify(input int unsigned idx, input int unsigned nregs);
    if (idx < nregs) return SRC_REG;
    if (idx == nregs) return SRC_CNT;
    return SRC_FILL;
  endfunction

endpackage

// File: rtl/sbus_reg_file.sv
module sbus_reg_file #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 64,
  parameter int SEL_ADDR = 124
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stb,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [ADDR_W-1:0]          rb_idx
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              sel_hit;
  logic              reg_hit;

  assign sel_hit = stb && (addr == ADDR_W'(SEL_ADDR));
  assign reg_hit = stb && (int'(addr) < NUM_REGS) && !sel_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (stb && (addr == ADDR_W'(g)) && (g != SEL_ADDR)) begin
        regs[g] <= wdata;
      end
    end
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_idx <= '0;
    end else if (sel_hit) begin
      rb_idx <= wdata[ADDR_W-1:0];
    end
  end

  // R4: reserved address loads the index from the low data bits
  p_sel_capture_r4: assert property (@(posedge clk) disable iff (rst)
    sel_hit |=> rb_idx == $past(wdata[ADDR_W-1:0]));

  // R4/R8: index holds on any other strobe or idle cycle
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_hit |=> $stable(rb_idx));

  // R3: written register holds the written data afterwards
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    reg_hit |=> regs[$past(addr[IDX_W-1:0])] == $past(wdata));

  // R1: reset clears the index
  p_reset_idx_r1: assert property (@(posedge clk)
    rst |=> rb_idx == '0);

endmodule

// File: rtl/sbus_rb_mux.sv
module sbus_rb_mux
  import sbus_slave_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          RB_W      = 64,
  parameter int          NUM_REGS  = 64,
  parameter logic [63:0] FILL_WORD = 64'hA5A5_5A5A_0123_4567
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          rb_idx,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [RB_W-1:0]            rb_word
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [RB_W-1:0]  free_cnt;
  logic [IDX_W-1:0] reg_sel;
  rb_src_e          src;

  always_ff @(posedge clk) begin
    if (rst) free_cnt <= '0;
    else     free_cnt <= free_cnt + 1'b1;
  end

  assign reg_sel = rb_idx[IDX_W-1:0];
  assign src     = classify(int'(rb_idx), NUM_REGS);

  always_comb begin
    unique case (src)
      SRC_REG:  rb_word = RB_W'(regs_flat[int'(reg_sel)*DATA_W +: DATA_W]);
      SRC_CNT:  rb_word = free_cnt;
      default:  rb_word = RB_W'(FILL_WORD);
    endcase
  end

  // R6: counter advances by one every clock outside reset
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> free_cnt == $past(free_cnt) + 1'b1);

endmodule

// File: rtl/sbus_ack_pipe.sv
module sbus_ack_pipe #(
  parameter int          ADDR_W    = 8,
  parameter int          RB_W      = 64,
  parameter int          TIME_W    = 64,
  parameter int          NUM_REGS  = 64,
  parameter logic [63:0] FILL_WORD = 64'hA5A5_5A5A_0123_4567
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [TIME_W-1:0] cfg_time,
  input  logic              cfg_timed,
  input  logic [ADDR_W-1:0] rb_idx,
  input  logic [RB_W-1:0]   rb_word,
  output logic              ack_stb,
  output logic [RB_W-1:0]   ack_data,
  output logic [TIME_W-1:0] last_time,
  output logic              last_timed
);
  logic stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= 1'b0;
      ack_stb  <= 1'b0;
      ack_data <= '0;
    end else begin
      stage1  <= stb;
      ack_stb <= stage1;
      if (stage1) ack_data <= rb_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_time  <= '0;
      last_timed <= 1'b0;
    end else if (stb) begin
      last_time  <= cfg_time;
      last_timed <= cfg_timed;
    end
  end

  // R2: an acknowledge is always preceded by a strobe two cycles earlier
  p_ack_lat_r2: assert property (@(posedge clk) disable iff (rst)
    ack_stb |-> $past(stb, 2));

  // R2: at most one transaction in flight
  p_one_flight_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stage1, ack_stb}));

  // R7: indices above the counter return the constant word
  p_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && (int'($past(rb_idx)) > NUM_REGS)) |-> ack_data == RB_W'(FILL_WORD));

  // R9: time fields latch on the strobe
  p_time_latch_r9: assert property (@(posedge clk) disable iff (rst)
    stb |=> (last_time == $past(cfg_time)) && (last_timed == $past(cfg_timed)));

  // R10: reset kills any pending acknowledge
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> !ack_stb);

endmodule

// File: rtl/sbus_reg_slave.sv
module sbus_reg_slave #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          RB_W      = 64,
  parameter int          TIME_W    = 64,
  parameter int          NUM_REGS  = 64,
  parameter int          SEL_ADDR  = 124,
  parameter logic [63:0] FILL_WORD = 64'hA5A5_5A5A_0123_4567
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_stb,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [TIME_W-1:0] cfg_time,
  input  logic              cfg_timed,
  output logic              ack_stb,
  output logic [RB_W-1:0]   ack_data,
  output logic [TIME_W-1:0] last_time,
  output logic              last_timed
);
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic [ADDR_W-1:0]          rb_idx;
  logic [RB_W-1:0]            rb_word;

  sbus_reg_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_ADDR(SEL_ADDR)
  ) i_reg_file (
    .clk(clk), .rst(rst), .stb(cfg_stb), .addr(cfg_addr), .wdata(cfg_wdata),
    .regs_flat(regs_flat), .rb_idx(rb_idx)
  );

  sbus_rb_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RB_W(RB_W), .NUM_REGS(NUM_REGS),
    .FILL_WORD(FILL_WORD)
  ) i_rb_mux (
    .clk(clk), .rst(rst), .rb_idx(rb_idx), .regs_flat(regs_flat), .rb_word(rb_word)
  );

  sbus_ack_pipe #(
    .ADDR_W(ADDR_W), .RB_W(RB_W), .TIME_W(TIME_W), .NUM_REGS(NUM_REGS),
    .FILL_WORD(FILL_WORD)
  ) i_ack_pipe (
    .clk(clk), .rst(rst), .stb(cfg_stb), .cfg_time(cfg_time), .cfg_timed(cfg_timed),
    .rb_idx(rb_idx), .rb_word(rb_word), .ack_stb(ack_stb), .ack_data(ack_data),
    .last_time(last_time), .last_timed(last_timed)
  );

endmodule

// File: tb/test_sbus_reg_slave.sv
module test_sbus_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FILL = 64'hA5A5_5A5A_0123_4567;

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic [63:0] e;
    logic [7:0]  req;
  } vec_t;

  // Each strobe returns the word picked by the index after that strobe's edge.
  localparam vec_t VECS [11] = '{
    '{8'd5,   32'h1111_0005, 64'h0,           8'd3}, // R3 write reg5, idx0 -> reg0=0
    '{8'd0,   32'hCAFE_0000, 64'hCAFE_0000,   8'd3}, // R3 write reg0, seen at once
    '{8'd124, 32'd5,         64'h1111_0005,   8'd4}, // R4 idx=5
    '{8'd63,  32'hFFFF_003F, 64'h1111_0005,   8'd5}, // R5 idx unchanged
    '{8'd124, 32'd63,        64'hFFFF_003F,   8'd5}, // R5 top register
    '{8'd70,  32'hBAD0_0046, 64'hFFFF_003F,   8'd8}, // R8 ignored write
    '{8'd124, 32'd6,         64'h0,           8'd8}, // R8 reg6 untouched
    '{8'd124, 32'd65,        FILL,            8'd7}, // R7 first constant index
    '{8'd124, 32'd255,       FILL,            8'd7}, // R7 last index
    '{8'd124, 32'h0000_0100, 64'hCAFE_0000,   8'd4}, // R4 upper bits ignored
    '{8'd124, 32'd127,       FILL,            8'd7}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_stb = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [63:0] cfg_time = '0;
  logic        cfg_timed = 1'b0;
  logic        ack_stb;
  logic [63:0] ack_data;
  logic [63:0] last_time;
  logic        last_timed;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_reg_slave i_sbus_reg_slave (
    .clk(clk), .rst(rst), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_time(cfg_time), .cfg_timed(cfg_timed),
    .ack_stb(ack_stb), .ack_data(ack_data), .last_time(last_time),
    .last_timed(last_timed)
  );

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns there three cycles later.
  task automatic xact(input logic [7:0] a, input logic [31:0] d, input logic [63:0] t,
                      input logic tm, output logic [63:0] got);
    cfg_addr = a; cfg_wdata = d; cfg_time = t; cfg_timed = tm; cfg_stb = 1'b1;
    @(negedge clk);
    cfg_stb = 1'b0;
    check_eq("R2 no early ack", 64'(ack_stb), 64'd0);
    @(negedge clk);
    check_eq("R2 ack in second cycle", 64'(ack_stb), 64'd1);
    got = ack_data;
    @(negedge clk);
    check_eq("R2 ack one cycle wide", 64'(ack_stb), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] got;
    logic [63:0] c1;
    logic [63:0] c2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 ack low after reset", 64'(ack_stb), 64'd0);
    check_eq("R1 time cleared", last_time, 64'd0);
    check_eq("R1 timed flag cleared", 64'(last_timed), 64'd0);

    for (int i = 0; i < 11; i++) begin
      xact(VECS[i].a, VECS[i].d, 64'd0, 1'b0, got);
      check_eq($sformatf("R%0d vector %0d data", VECS[i].req, i), got, VECS[i].e);
    end

    // R6: counter reads three cycles apart
    xact(8'd124, 32'd64, 64'd0, 1'b0, c1);
    xact(8'd200, 32'd0, 64'd0, 1'b0, c2);
    check_eq("R6 counter step", c2 - c1, 64'd3);

    // R9: time fields latched
    xact(8'd200, 32'd0, 64'h0123_4567_89AB_CDEF, 1'b1, got);
    check_eq("R9 time", last_time, 64'h0123_4567_89AB_CDEF);
    check_eq("R9 timed", 64'(last_timed), 64'd1);
    xact(8'd200, 32'd0, 64'hFEDC_0000_0000_0042, 1'b0, got);
    check_eq("R9 time second", last_time, 64'hFEDC_0000_0000_0042);
    check_eq("R9 untimed", 64'(last_timed), 64'd0);

    // R10: reset while acknowledge is pending
    cfg_addr = 8'd124; cfg_wdata = 32'd0; cfg_stb = 1'b1;
    @(negedge clk);
    cfg_stb = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check_eq("R10 ack suppressed", 64'(ack_stb), 64'd0);
    check_eq("R1 time cleared by reset", last_time, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R10 no late ack", 64'(ack_stb), 64'd0);

    // R1: registers and index cleared (reg0 held CAFE0000 before)
    xact(8'd200, 32'd0, 64'd0, 1'b0, got);
    check_eq("R1 reg0 via idx0 after reset", got, 64'd0);
    xact(8'd124, 32'd5, 64'd0, 1'b0, got);
    check_eq("R1 reg5 after reset", got, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule